// File: doc/BRIEF.md
# Nine-Bit Multidrop Address Filter

This block sits between a UART receive shifter and the receive FIFO on a shared multidrop line. Every received character carries a ninth bit in the parity position: a one marks an address character and a zero marks a data character. The filter decides, character by character, whether the FIFO gets it, which per-character error flag goes with it, and whether the host gets a line-status interrupt request. It also tracks whether this station is currently listening.

Two nine-bit modes exist. In the host-arbitrated mode every address character is handed to the host with the error flag set, and only the host opens or closes reception. In the auto-detect mode the filter compares each address character with a programmed station address. A match opens reception and a mismatch closes it, without any host action. The host can still close reception when a message ends. With nine-bit operation off, the block is a plain pass-through.

Both character interfaces are valid/ready. A character is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the one-entry output register is empty or is being drained in that cycle. Once `out_valid` rises, the character and its flag stay unchanged until `out_ready` is seen high. Filtered-out characters are still accepted and are simply consumed.

Top module: `mdrop_addr_filter`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid`, `lsi_req` and `rx_enabled` are 0.
- R2: `in_ready` equals `!out_valid || out_ready`. A character that is stored appears on `out_data`/`out_flag` with `out_valid` high in the cycle after acceptance. A stored character stays unchanged while `out_ready` is low.
- R3: With `nine_bit_en` = 0, every accepted character is stored with `out_flag` = `in_perr`, and `lsi_req` stays 0.
- R4: With `nine_bit_en` = 1, `in_mark` = 1 means address and 0 means data. A data character accepted while `rx_enabled` is 0 is dropped, and `out_valid` stays 0 on the next cycle.
- R5: In host mode (`nine_bit_en` = 1, `auto_addr_en` = 0), every address character is stored with `out_flag` = 1, whatever the state of `rx_enabled`. The character does not change `rx_enabled`.
- R6: A `host_rx_enable` pulse sets `rx_enabled` and a `host_rx_disable` pulse clears it. When both are high in the same cycle, the disable wins. While `rx_enabled` is 1 in either nine-bit mode, data characters are stored with `out_flag` = 0.
- R7: In auto mode (`nine_bit_en` = 1, `auto_addr_en` = 1), an address character equal to `station_addr` sets `rx_enabled` and is stored with `out_flag` = 1. This holds whether reception was on or off.
- R8: In auto mode, an address character that differs from `station_addr` is not stored and clears `rx_enabled`.
- R9: When an auto-mode address character is accepted in the same cycle as a host enable or disable pulse, the match result decides `rx_enabled` and the host pulse is ignored.
- R10: `lsi_req` is a single-cycle pulse. It rises in the cycle after an address character is stored in a nine-bit mode, and only when `lsi_en` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Received character available |
| in_ready | output | 1 | Filter can take a character this cycle |
| in_data | input | DATA_W | Received character |
| in_mark | input | 1 | Ninth bit: 1 = address, 0 = data |
| in_perr | input | 1 | Parity error from the shifter, used when nine-bit mode is off |
| nine_bit_en | input | 1 | Enables multidrop filtering |
| auto_addr_en | input | 1 | Selects auto-detect over host-arbitrated mode |
| station_addr | input | DATA_W | Address this station answers to |
| lsi_en | input | 1 | Line-status interrupt enable |
| host_rx_enable | input | 1 | One-cycle host command: open reception |
| host_rx_disable | input | 1 | One-cycle host command: close reception |
| out_valid | output | 1 | Character waiting for the FIFO |
| out_ready | input | 1 | FIFO takes the character this cycle |
| out_data | output | DATA_W | Character to the FIFO |
| out_flag | output | 1 | Per-character error flag to the FIFO |
| lsi_req | output | 1 | Line-status interrupt request pulse |
| rx_enabled | output | 1 | Current receive-enabled state |

## Verification
`in_ready` depends only on present state, so it is due in the same cycle, before the edge. `out_valid`, `out_data`, `out_flag`, `lsi_req` and `rx_enabled` all come from registers that load on the edge that accepts a character or a host command. They are therefore due one time unit after that edge. The bench applies inputs just after an edge and checks `in_ready` one unit later. It then waits for the next rising edge, advances its reference model across that edge, and compares every output one unit after it. A stall keeps the expected character unchanged in the model, so the hold rule is checked on every stalled cycle.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;

  // What an accepted character does to the receive-enabled state
  typedef enum logic [1:0] {
    GATE_KEEP = 2'd0,
    GATE_OPEN = 2'd1,
    GATE_SHUT = 2'd2
  } gate_act_e;

  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_HOST = 2'd1,
    MODE_AUTO = 2'd2
  } filt_mode_e;

  function automatic filt_mode_e mode_of(input logic nine_bit, input logic auto_det);
    if (!nine_bit)     return MODE_PASS;
    else if (auto_det) return MODE_AUTO;
    else               return MODE_HOST;
  endfunction

endpackage

// File: rtl/mdrop_classify.sv
module mdrop_classify
  import mdrop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              accept,
  input  filt_mode_e        mode,
  input  logic [DATA_W-1:0] ch_data,
  input  logic              ch_mark,
  input  logic              ch_perr,
  input  logic [DATA_W-1:0] own_addr,
  input  logic              listening,
  input  logic              lsi_en,
  output logic              push,
  output logic              push_flag,
  output logic              push_lsi,
  output gate_act_e         gate_act
);

  logic addr_hit;

  assign addr_hit = (ch_data == own_addr);

  always_comb begin
    push      = 1'b0;
    push_flag = 1'b0;
    push_lsi  = 1'b0;
    gate_act  = GATE_KEEP;
    if (accept) begin
      unique case (mode)
        MODE_PASS: begin
          push      = 1'b1;
          push_flag = ch_perr;
        end
        MODE_HOST: begin
          if (ch_mark) begin
            push      = 1'b1;
            push_flag = 1'b1;
            push_lsi  = lsi_en;
          end else begin
            push = listening;
          end
        end
        MODE_AUTO: begin
          if (ch_mark) begin
            if (addr_hit) begin
              push      = 1'b1;
              push_flag = 1'b1;
              push_lsi  = lsi_en;
              gate_act  = GATE_OPEN;
            end else begin
              gate_act  = GATE_SHUT;
            end
          end else begin
            push = listening;
          end
        end
        default: begin
          push = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/mdrop_rx_gate.sv
module mdrop_rx_gate
  import mdrop_pkg::*;
#(
  parameter bit DIS_WINS = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  gate_act_e gate_act,
  input  logic      host_en,
  input  logic      host_dis,
  output logic      listening
);

  logic host_next;
  logic gate_next;

  // Priority between simultaneous host commands is a build-time choice
  generate
    if (DIS_WINS) begin : g_dis_first
      assign host_next = host_dis ? 1'b0 : (host_en ? 1'b1 : listening);
    end else begin : g_en_first
      assign host_next = host_en ? 1'b1 : (host_dis ? 1'b0 : listening);
    end
  endgenerate

  // An automatic decision overrides any host command in the same cycle
  always_comb begin
    unique case (gate_act)
      GATE_OPEN: gate_next = 1'b1;
      GATE_SHUT: gate_next = 1'b0;
      default:   gate_next = host_next;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) listening <= 1'b0;
    else        listening <= gate_next;
  end

endmodule

// File: rtl/mdrop_out_stage.sv
module mdrop_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              ld_flag,
  input  logic              ld_lsi,
  output logic              take_ok,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_flag,
  output logic              lsi_req
);

  assign take_ok = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_flag  <= 1'b0;
      lsi_req   <= 1'b0;
    end else begin
      lsi_req <= load && ld_lsi;
      if (load) begin
        out_valid <= 1'b1;
        out_data  <= ld_data;
        out_flag  <= ld_flag;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mdrop_addr_filter.sv
module mdrop_addr_filter
  import mdrop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_mark,
  input  logic              in_perr,
  input  logic              nine_bit_en,
  input  logic              auto_addr_en,
  input  logic [DATA_W-1:0] station_addr,
  input  logic              lsi_en,
  input  logic              host_rx_enable,
  input  logic              host_rx_disable,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_flag,
  output logic              lsi_req,
  output logic              rx_enabled
);

  logic       accept;
  logic       push;
  logic       push_flag;
  logic       push_lsi;
  gate_act_e  gate_act;
  filt_mode_e mode;

  assign mode   = mode_of(nine_bit_en, auto_addr_en);
  assign accept = in_valid && in_ready;

  mdrop_classify #(.DATA_W(DATA_W)) u_classify (
    .accept    (accept),
    .mode      (mode),
    .ch_data   (in_data),
    .ch_mark   (in_mark),
    .ch_perr   (in_perr),
    .own_addr  (station_addr),
    .listening (rx_enabled),
    .lsi_en    (lsi_en),
    .push      (push),
    .push_flag (push_flag),
    .push_lsi  (push_lsi),
    .gate_act  (gate_act)
  );

  mdrop_rx_gate #(.DIS_WINS(1'b1)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_act  (gate_act),
    .host_en   (host_rx_enable),
    .host_dis  (host_rx_disable),
    .listening (rx_enabled)
  );

  mdrop_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (push),
    .ld_data   (in_data),
    .ld_flag   (push_flag),
    .ld_lsi    (push_lsi),
    .take_ok   (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_flag  (out_flag),
    .lsi_req   (lsi_req)
  );

endmodule

// File: rtl/mdrop_addr_filter_chk.sv
module mdrop_addr_filter_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              in_mark,
  input logic              in_perr,
  input logic              nine_bit_en,
  input logic              auto_addr_en,
  input logic [DATA_W-1:0] station_addr,
  input logic              lsi_en,
  input logic              host_rx_enable,
  input logic              host_rx_disable,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_flag,
  input logic              lsi_req,
  input logic              rx_enabled
);

  logic take;
  logic auto_hit;
  assign take     = in_valid && in_ready;
  assign auto_hit = take && nine_bit_en && auto_addr_en && in_mark && (in_data == station_addr);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_flag));

  // R2
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R3
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !nine_bit_en |=> out_valid && out_data == $past(in_data)
                             && out_flag == $past(in_perr) && !lsi_req);

  // R4
  drop_idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && nine_bit_en && !in_mark && !rx_enabled |=> !out_valid);

  // R5
  host_addr_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && nine_bit_en && !auto_addr_en && in_mark |=> out_valid && out_flag);

  // R7
  auto_match_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_hit |=> rx_enabled && out_valid && out_flag);

  // R8
  auto_miss_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && nine_bit_en && auto_addr_en && in_mark && (in_data != station_addr)
      |=> !rx_enabled);

  // R6
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_enabled) |-> $past(host_rx_enable) || $past(auto_hit));

  // R10
  lsi_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lsi_req |-> out_valid && out_flag && $past(lsi_en) && $past(nine_bit_en));

endmodule

bind mdrop_addr_filter mdrop_addr_filter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .in_valid        (in_valid),
  .in_ready        (in_ready),
  .in_data         (in_data),
  .in_mark         (in_mark),
  .in_perr         (in_perr),
  .nine_bit_en     (nine_bit_en),
  .auto_addr_en    (auto_addr_en),
  .station_addr    (station_addr),
  .lsi_en          (lsi_en),
  .host_rx_enable  (host_rx_enable),
  .host_rx_disable (host_rx_disable),
  .out_valid       (out_valid),
  .out_ready       (out_ready),
  .out_data        (out_data),
  .out_flag        (out_flag),
  .lsi_req         (lsi_req),
  .rx_enabled      (rx_enabled)
);

// File: tb/test_mdrop_addr_filter.sv
module test_mdrop_addr_filter;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_mark = 0, in_perr = 0;
  logic [DW-1:0] in_data = '0, station_addr = 8'h5A;
  logic nine_bit_en = 0, auto_addr_en = 0, lsi_en = 1;
  logic host_rx_enable = 0, host_rx_disable = 0, out_ready = 1;
  logic in_ready, out_valid, out_flag, lsi_req, rx_enabled;
  logic [DW-1:0] out_data;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference state
  logic m_en = 0, m_ov = 0, m_of = 0, m_lsi = 0;
  logic [DW-1:0] m_od = '0;

  typedef struct packed {logic push; logic flag; logic lsi; logic [1:0] act;} dec_t;

  mdrop_addr_filter #(.DATA_W(DW)) i_mdrop_addr_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_mark(in_mark), .in_perr(in_perr),
    .nine_bit_en(nine_bit_en), .auto_addr_en(auto_addr_en),
    .station_addr(station_addr), .lsi_en(lsi_en),
    .host_rx_enable(host_rx_enable), .host_rx_disable(host_rx_disable),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_flag(out_flag), .lsi_req(lsi_req), .rx_enabled(rx_enabled));

  always #(CLK_PERIOD/2) clk = ~clk;

  // act: 0 keep, 1 open, 2 shut
  function automatic dec_t ref_decide(input logic acc, input logic nbe, input logic aut,
                                      input logic mk, input logic pe, input logic [DW-1:0] d,
                                      input logic [DW-1:0] sa, input logic en, input logic le);
    dec_t r = '0;
    if (acc) begin
      if (!nbe) begin r.push = 1; r.flag = pe; end
      else if (mk && !aut) begin r.push = 1; r.flag = 1; r.lsi = le; end
      else if (mk && aut) begin
        if (d == sa) begin r.push = 1; r.flag = 1; r.lsi = le; r.act = 2'd1; end
        else r.act = 2'd2;
      end else r.push = en;
    end
    return r;
  endfunction

  function automatic logic ref_next_en(input logic [1:0] act, input logic en,
                                       input logic he, input logic hd);
    if (act == 2'd1) return 1'b1;
    if (act == 2'd2) return 1'b0;
    if (hd) return 1'b0;
    if (he) return 1'b1;
    return en;
  endfunction

  task automatic check1(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic drive(input logic v, input logic [DW-1:0] d, input logic mk, input logic pe,
                       input logic he, input logic hd, input logic rdy);
    in_valid = v; in_data = d; in_mark = mk; in_perr = pe;
    host_rx_enable = he; host_rx_disable = hd; out_ready = rdy;
  endtask

  // inputs were set just after the previous edge
  task automatic step(input string force_tag);
    dec_t dc;
    logic acc;
    string tag;
    #1;
    acc = in_valid && (!m_ov || out_ready);
    check1("R2", "in_ready", in_ready, !m_ov || out_ready);
    dc = ref_decide(acc, nine_bit_en, auto_addr_en, in_mark, in_perr, in_data,
                    station_addr, m_en, lsi_en);
    if (force_tag != "") tag = force_tag;
    else if (dc.act != 0 && (host_rx_enable || host_rx_disable)) tag = "R9";
    else if (acc && !nine_bit_en) tag = "R3";
    else if (dc.act == 2'd1) tag = "R7";
    else if (dc.act == 2'd2) tag = "R8";
    else if (acc && in_mark) tag = "R5";
    else if (acc && !m_en) tag = "R4";
    else if (host_rx_enable || host_rx_disable || acc) tag = "R6";
    else tag = "R2";
    m_en = ref_next_en(dc.act, m_en, host_rx_enable, host_rx_disable);
    m_lsi = dc.lsi;
    if (dc.push) begin m_ov = 1; m_od = in_data; m_of = dc.flag; end
    else if (out_ready) m_ov = 0;
    @(posedge clk);
    #1;
    check1(tag, "out_valid", out_valid, m_ov);
    if (m_ov) begin
      check1(tag, "out_data", out_data, m_od);
      check1(tag, "out_flag", out_flag, m_of);
    end
    check1(m_lsi || lsi_req ? "R10" : tag, "lsi_req", lsi_req, m_lsi);
    check1(tag, "rx_enabled", rx_enabled, m_en);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state
    #(2*CLK_PERIOD + 1);
    check1("R1", "out_valid", out_valid, 0);
    check1("R1", "lsi_req", lsi_req, 0);
    check1("R1", "rx_enabled", rx_enabled, 0);
    @(posedge clk); #1 rst_n = 1;
    drive(0, 0, 0, 0, 0, 0, 1);
    step("R1");

    // R3: pass-through keeps the parity error as the flag
    nine_bit_en = 0;
    drive(1, 8'h33, 1, 1, 0, 0, 1); step("R3");
    drive(1, 8'h34, 0, 0, 0, 0, 1); step("R3");

    // host mode
    nine_bit_en = 1; auto_addr_en = 0;
    drive(1, 8'h11, 0, 0, 0, 0, 1); step("R4");
    drive(1, 8'h77, 1, 0, 0, 0, 1); step("R5");
    drive(0, 0, 0, 0, 1, 0, 1);     step("R6");
    drive(1, 8'h22, 0, 1, 0, 0, 0); step("R6");
    drive(1, 8'h23, 0, 0, 0, 0, 0); step("R2");   // stalled, must hold
    drive(1, 8'h23, 0, 0, 0, 0, 1); step("R2");
    drive(1, 8'h66, 1, 0, 0, 0, 1); step("R5");
    drive(0, 0, 0, 0, 1, 1, 1);     step("R6");   // disable wins
    lsi_en = 0;
    drive(1, 8'h55, 1, 0, 0, 0, 1); step("R10");
    lsi_en = 1;

    // auto mode
    auto_addr_en = 1;
    drive(1, 8'h5B, 1, 0, 0, 0, 1); step("R8");
    drive(1, 8'h5A, 1, 0, 0, 0, 1); step("R7");
    drive(1, 8'h01, 0, 0, 0, 0, 1); step("R6");
    drive(1, 8'h5A, 1, 0, 0, 0, 1); step("R7");
    drive(1, 8'h5A, 1, 0, 0, 1, 1); step("R9");   // match beats host disable
    drive(1, 8'h40, 1, 0, 0, 0, 1); step("R8");
    drive(1, 8'h02, 0, 0, 0, 0, 1); step("R4");
    drive(1, 8'h41, 1, 0, 1, 0, 1); step("R9");   // miss beats host enable
    drive(1, 8'h5A, 1, 0, 0, 0, 1); step("R7");
    drive(0, 0, 0, 0, 0, 1, 1);     step("R6");

    // constrained random phases
    for (int ph = 0; ph < 12; ph++) begin
      nine_bit_en  = (ph % 3) != 0;
      auto_addr_en = (ph % 3) == 2;
      lsi_en       = $urandom_range(0, 3) != 0;
      station_addr = 8'($urandom);
      for (int k = 0; k < 400; k++) begin
        logic mk;
        logic [DW-1:0] d;
        mk = $urandom_range(0, 3) == 0;
        d  = (mk && $urandom_range(0, 1) == 1) ? station_addr : 8'($urandom);
        drive($urandom_range(0, 3) != 0, d, mk, $urandom_range(0, 7) == 0,
              $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0,
              $urandom_range(0, 3) != 0);
        step("");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule